// File: doc/BRIEF.md
# Serial Module Low-Power Mode Controller

This block moves a serial shift peripheral into and out of two low-power conditions and reports which condition is in force. The first condition is a system stop handshake. A stop request is acknowledged on the next clock. The indication that clocks may be gated is raised only once the shift engine is idle or has reached the end of the current frame. The second condition is a module disable. A software control bit or a hardware input can request it. Clock enable drops at the next frame boundary, not at once.

While the module is disabled, its registers stay readable, but the block blocks the side effects of a set of register accesses. Receive pops, transmit pushes, FIFO clears, FIFO-disable field writes, transfer-attribute writes and status-flag writes are all suppressed. Interrupt and DMA request lines pass through a register stage. That stage freezes them during external stop and lets them rise but not fall while the module is disabled. The shift engine, FIFOs and register file are outside this block. It produces only their qualifying enables.

Top module: `lpm_ctrl`

## Requirements
- R1: `stop_ack_o` equals `stop_req_i` delayed by exactly one clock.
- R2: `stop_ready_o` rises one clock after a cycle in which `stop_req_i` is high and a boundary is present (`xfer_active_i` low, or `frame_end_i` high). While the transfer is active with no frame end, it stays low. It falls one clock after `stop_req_i` drops.
- R3: `running_o` is 1 exactly when the block is not STOPPED. It equals `clk_en_o` and is 0 whenever stop entry or disable entry has completed.
- R4: With disable requested, `clk_en_o` falls one clock after the first cycle that has a boundary, not before.
- R5: A hardware disable (`dis_hw_i`) alone enters disable exactly as the software bit (`dis_sw_i`) does.
- R6: When both disable inputs are low and no stop has been entered, `clk_en_o` returns high on the next clock.
- R7: `access_o` equals `access_req_i` while the module is not disabled and is all zero while it is disabled. Bit encoding: bit 0 receive pop, bit 1 transmit/command push, bit 2 FIFO clear, bit 3 FIFO-disable field write, bit 4 transfer-attribute write, bit 5 status-flag write.
- R8: While stop entry has completed, `event_o` holds its value. Bit 0 is the interrupt request and bit 1 the DMA request.
- R9: While disabled and not stopped, a bit of `event_o` may go from 0 to 1 but never from 1 to 0.
- R10: If stop and disable overlap, the block stays STOPPED until both are released.
- R11: After reset: `stop_ack_o`=0, `stop_ready_o`=0, `clk_en_o`=1, `running_o`=1, `event_o`=0.
- R12: When neither stopped nor disabled, `event_o` equals `event_i` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_i | input | 1 | System stop request |
| stop_ack_o | output | 1 | Stop acknowledge |
| stop_ready_o | output | 1 | Safe to gate clocks for stop |
| dis_sw_i | input | 1 | Software disable control bit |
| dis_hw_i | input | 1 | Hardware disable request |
| xfer_active_i | input | 1 | Shift engine is mid-transfer |
| frame_end_i | input | 1 | Current frame reaches its boundary this cycle |
| clk_en_o | output | 1 | Clock enable for non-register logic |
| running_o | output | 1 | Transfer running status, 0 when STOPPED |
| access_req_i | input | 6 | Raw register-access side-effect strobes |
| access_o | output | 6 | Qualified side-effect strobes |
| event_i | input | 2 | Raw interrupt / DMA requests |
| event_o | output | 2 | Held interrupt / DMA requests |

## Verification
On every cycle, the in-line assertions check the acknowledge delay and the hold of the ready indication during a mid-frame transfer. They also check that status reads 0 once stop is entered, that strobes are blocked once clock enable is down without a stop, and that request lines are frozen in stop and never cleared in disable. Other behaviour can only be shown by the bench's scenarios against its cycle model. That covers the exact entry cycle after a delayed frame end, the equivalence of hardware and software disable, re-enable on the next clock, and the release order of overlapping stop and disable.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned ACC_W    = 6;
  localparam int unsigned EVT_W    = 2;
  localparam int unsigned ACC_RX_POP  = 0;
  localparam int unsigned ACC_TX_PUSH = 1;
  localparam int unsigned ACC_CLR     = 2;
  localparam int unsigned ACC_FDIS    = 3;
  localparam int unsigned ACC_ATTR    = 4;
  localparam int unsigned ACC_FLAG    = 5;
  typedef logic [ACC_W-1:0] acc_vec_t;
endpackage

// File: rtl/lpm_entry.sv
// Entry tracker: done once request seen together with a frame boundary.
module lpm_entry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic boundary_i,
  output logic done_o
);
  logic done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= req_i & (done_q | boundary_i);
  end

  assign done_o = done_q;

  a_r2_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  a_r2_wait_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !done_o && !boundary_i) |=> !done_o);
endmodule

// File: rtl/lpm_access_gate.sv
module lpm_access_gate #(
  parameter int unsigned W = lpm_pkg::ACC_W
) (
  input  logic         blocked_i,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] qual_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign qual_o[g] = req_i[g] & ~blocked_i;
  end
endmodule

// File: rtl/lpm_event_hold.sv
// Request lines: frozen in stop, sticky-high in disable, pass-through otherwise.
module lpm_event_hold #(
  parameter int unsigned W = lpm_pkg::EVT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_i,
  input  logic         dis_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] evt_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     evt_q[g] <= 1'b0;
      else if (stop_i) evt_q[g] <= evt_q[g];
      else if (dis_i)  evt_q[g] <= evt_q[g] | evt_i[g];
      else             evt_q[g] <= evt_i[g];
    end
  end

  assign evt_o = evt_q;

  a_r8_stop_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(evt_o));
  a_r9_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i && !stop_i) |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int unsigned ACC_W = lpm_pkg::ACC_W,
  parameter int unsigned EVT_W = lpm_pkg::EVT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  output logic             stop_ack_o,
  output logic             stop_ready_o,
  input  logic             dis_sw_i,
  input  logic             dis_hw_i,
  input  logic             xfer_active_i,
  input  logic             frame_end_i,
  output logic             clk_en_o,
  output logic             running_o,
  input  logic [ACC_W-1:0] access_req_i,
  output logic [ACC_W-1:0] access_o,
  input  logic [EVT_W-1:0] event_i,
  output logic [EVT_W-1:0] event_o
);
  logic boundary, dis_req, stop_done, dis_done, ack_q;

  assign boundary = ~xfer_active_i | frame_end_i;
  assign dis_req  = dis_sw_i | dis_hw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= stop_req_i;
  end

  lpm_entry i_stop_entry (
    .clk_i, .rst_ni, .req_i(stop_req_i), .boundary_i(boundary), .done_o(stop_done)
  );

  lpm_entry i_dis_entry (
    .clk_i, .rst_ni, .req_i(dis_req), .boundary_i(boundary), .done_o(dis_done)
  );

  lpm_access_gate #(.W(ACC_W)) i_gate (
    .blocked_i(dis_done), .req_i(access_req_i), .qual_o(access_o)
  );

  lpm_event_hold #(.W(EVT_W)) i_evt (
    .clk_i, .rst_ni, .stop_i(stop_done), .dis_i(dis_done),
    .evt_i(event_i), .evt_o(event_o)
  );

  assign stop_ack_o   = ack_q;
  assign stop_ready_o = stop_done;
  assign clk_en_o     = ~(stop_done | dis_done);
  assign running_o    = clk_en_o;

  a_r1_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_req_i |=> stop_ack_o);
  a_r1_ack_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_req_i |=> !stop_ack_o);
  a_r3_stopped_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ready_o |-> !running_o);
  a_r7_gate_in_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && !stop_ready_o) |-> (access_o == '0));
  a_r4_no_early_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !stop_req_i && xfer_active_i && !frame_end_i) |=> clk_en_o);
endmodule

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
  logic clk = 0, rst_n = 0;
  logic stop_req = 0, dis_sw = 0, dis_hw = 0, xfer = 0, fend = 0;
  logic [5:0] acc = '0;
  logic [1:0] evt = '0;
  logic stop_ack, stop_ready, clk_en, running;
  logic [5:0] acc_o;
  logic [1:0] evt_o;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_ctrl i_lpm_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .stop_req_i(stop_req), .stop_ack_o(stop_ack),
    .stop_ready_o(stop_ready), .dis_sw_i(dis_sw), .dis_hw_i(dis_hw),
    .xfer_active_i(xfer), .frame_end_i(fend), .clk_en_o(clk_en),
    .running_o(running), .access_req_i(acc), .access_o(acc_o),
    .event_i(evt), .event_o(evt_o)
  );

  // behavioural reference
  bit m_ack, m_stop, m_dis;
  bit [1:0] m_evt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 0; m_stop <= 0; m_dis <= 0; m_evt <= 0;
    end else begin
      m_ack  <= stop_req;
      m_stop <= stop_req && (m_stop || !xfer || fend);
      m_dis  <= (dis_sw || dis_hw) && (m_dis || !xfer || fend);
      if (m_stop)     m_evt <= m_evt;
      else if (m_dis) m_evt <= m_evt | evt;
      else            m_evt <= evt;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 ack", stop_ack, m_ack);
    chk("R2 ready", stop_ready, m_stop);
    chk("R4 clk_en", clk_en, !(m_stop || m_dis));
    chk("R3 running", running, !(m_stop || m_dis));
    chk("R7 access", acc_o, m_dis ? 6'h0 : acc);
    chk(m_stop ? "R8 event" : (m_dis ? "R9 event" : "R12 event"), evt_o, m_evt);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); #1;
      compare_all();
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #23; #1;
    // R11 reset state
    chk("R11 ack", stop_ack, 0); chk("R11 ready", stop_ready, 0);
    chk("R11 clk_en", clk_en, 1); chk("R11 running", running, 1);
    chk("R11 event", evt_o, 0);
    rst_n = 1;
    @(negedge clk); #1;
    // R12 pass-through
    evt = 2'b01; acc = 6'h3f; tick();
    evt = 2'b10; acc = 6'h15; tick();
    evt = 2'b11; tick();
    // stop while idle: entry in one clock
    stop_req = 1; tick();
    chk("R2 idle entry", stop_ready, 1);
    evt = 2'b00; tick(3);
    chk("R8 frozen", evt_o, 2'b11);
    stop_req = 0; tick(2);
    // stop during active transfer, frame end after 3 cycles
    xfer = 1; stop_req = 1; tick(3);
    chk("R2 withheld", stop_ready, 0);
    fend = 1; tick(); fend = 0;
    chk("R2 at boundary", stop_ready, 1);
    tick(2); stop_req = 0; xfer = 0; tick(2);
    // software disable during transfer
    xfer = 1; dis_sw = 1; evt = 2'b01; tick(2);
    chk("R4 deferred", clk_en, 1);
    fend = 1; tick(); fend = 0;
    chk("R4 negated", clk_en, 0);
    acc = 6'h3f; evt = 2'b00; tick();
    chk("R7 blocked", acc_o, 0);
    evt = 2'b10; tick(); evt = 2'b00; tick();
    chk("R9 sticky", evt_o, 2'b11);
    dis_sw = 0; xfer = 0; tick();
    chk("R6 reenable", clk_en, 1);
    // hardware disable alone
    dis_hw = 1; tick();
    chk("R5 hw disable", clk_en, 0);
    dis_hw = 0; tick();
    chk("R6 hw release", clk_en, 1);
    // overlap
    stop_req = 1; dis_sw = 1; tick(2);
    stop_req = 0; tick(2);
    chk("R10 still stopped", running, 0);
    stop_req = 1; dis_sw = 0; tick(2);
    chk("R10 stop only", running, 0);
    stop_req = 0; tick();
    chk("R10 released", running, 1);
    // random phase
    for (int i = 0; i < 2000; i++) begin
      xfer = $urandom_range(0, 3) != 0;
      fend = $urandom_range(0, 4) == 0;
      acc  = 6'($urandom);
      evt  = 2'($urandom);
      if ($urandom_range(0, 9) == 0) stop_req = ~stop_req;
      if ($urandom_range(0, 11) == 0) dis_sw = ~dis_sw;
      if ($urandom_range(0, 17) == 0) dis_hw = ~dis_hw;
      tick();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule